// File: doc/BRIEF.md
# Registered Inverting Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B. Each direction has its own capture register, loaded on a rising edge of its own capture strobe. Each direction also has a source select that picks what is driven onto the far bus: either the live value of the near bus or the value held in that direction's register. Whatever is driven is the bitwise complement of the selected data. Two active-high enables decide whether the A-to-B path drives bus B and whether the B-to-A path drives bus A. Either, both or neither may be on.

Bus pins are modelled as separate vectors for synthesis. For each side there is an external value and a per-bit external-drive mask coming in, a value and a per-bit drive mask going out, and the resolved bus level the block sees. A bit that no one drives keeps its last level. Suppose both paths are enabled in live mode and the external drivers let go. Each bus then keeps its level, because each path drives the complement of the other bus.

The capture strobes are sampled on the system clock, and a rising edge is detected there. The resolved buses are kept in one register per bit.

Top module: `inv_bus_xcvr`

## Requirements
- R1: On the first clock edge where `cap_ab` is 1 after being 0, the A register loads the resolved A bus. This happens whatever `en_ab`, `en_ba`, `sel_ab` and `sel_ba` are.
- R2: On the first clock edge where `cap_ba` is 1 after being 0, the B register loads the resolved B bus. This happens whatever the enables and selects are.
- R3: While a strobe stays high, or stays low, its register keeps its value. A change on the bus during that time does not reach the register.
- R4: With `en_ab`=1 and `sel_ab`=0 (live), `b_drv_v` is the bitwise inverse of `a_seen`. With `en_ba`=1 and `sel_ba`=0, `a_drv_v` is the inverse of `b_seen`. Both follow the bus in the same cycle.
- R5: With `en_ab`=1 and `sel_ab`=1 (stored), `b_drv_v` is the inverse of the A register. With `en_ba`=1 and `sel_ba`=1, `a_drv_v` is the inverse of the B register. Changes on the live bus have no effect on them.
- R6: `b_drv_oe` is all ones exactly when `en_ab`=1 and reset is released, and all zeros otherwise. `a_drv_oe` is set the same way by `en_ba`. A path whose enable is off drives a value of zero.
- R7: For each bit, `a_seen` is `a_ext_v` where `a_ext_oe` is 1. Otherwise it is the level kept from the previous clock edge. That kept level is the block's own drive if `a_drv_oe` was 1, and the earlier level if it was not. Bus B works the same way.
- R8: Let both paths be enabled in live mode, with bus B carrying the complement of bus A. If all external drivers then let go, both buses keep their levels on every later clock. They also keep them after both enables go off.
- R9: While `rst_n`=0, both drive masks are zero. Both registers and both kept bus levels are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_ab | input | 1 | Capture strobe for the A register (rising edge) |
| cap_ba | input | 1 | Capture strobe for the B register (rising edge) |
| en_ab | input | 1 | Enable for the A-to-B path onto bus B |
| en_ba | input | 1 | Enable for the B-to-A path onto bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_ext_v | input | 8 | Value of the external driver on bus A |
| a_ext_oe | input | 8 | Per-bit mask of external drive on bus A |
| b_ext_v | input | 8 | Value of the external driver on bus B |
| b_ext_oe | input | 8 | Per-bit mask of external drive on bus B |
| a_drv_v | output | 8 | Value the block drives onto bus A |
| a_drv_oe | output | 8 | Per-bit drive mask onto bus A (0 = high impedance) |
| b_drv_v | output | 8 | Value the block drives onto bus B |
| b_drv_oe | output | 8 | Per-bit drive mask onto bus B (0 = high impedance) |
| a_seen | output | 8 | Resolved level of bus A |
| b_seen | output | 8 | Resolved level of bus B |

## Verification
The hardest state to reach from the ports is the self-holding loop. There, nothing outside drives either bus, and each level survives only because the two paths reinforce each other. The stimulus first drives A from outside with only the A-to-B path on, and lets the B keeper settle to the complement. In one step it then turns on the B-to-A path and releases the external driver. Both levels are watched over several clocks, and again after both paths are switched off.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  // level seen on one bus bit: external driver wins, else the kept level
  function automatic logic seen_bit(logic ext_oe, logic ext_v, logic kept);
    return ext_oe ? ext_v : kept;
  endfunction

  // next kept level of one bus bit
  function automatic logic keep_next(logic ext_oe, logic ext_v,
                                     logic own_oe, logic own_v, logic kept);
    if (ext_oe) return ext_v;
    if (own_oe) return own_v;
    return kept;
  endfunction

endpackage

// File: rtl/xcvr_edge_cap.sv
module xcvr_edge_cap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] bus,
  output logic         rise,
  output logic [W-1:0] held
);
  logic strobe_q;

  assign rise = strobe & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      held     <= '0;
    end else begin
      strobe_q <= strobe;
      if (rise) held <= bus;
    end
  end
endmodule

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ext_v,
  input  logic [W-1:0] ext_oe,
  input  logic [W-1:0] own_v,
  input  logic [W-1:0] own_oe,
  output logic [W-1:0] seen
);
  logic [W-1:0] kept_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign seen[i] = seen_bit(ext_oe[i], ext_v[i], kept_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kept_q[i] <= 1'b0;
      else        kept_q[i] <= keep_next(ext_oe[i], ext_v[i],
                                         own_oe[i], own_v[i], kept_q[i]);
    end
  end
endmodule

// File: rtl/xcvr_drive_path.sv
module xcvr_drive_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         en,
  input  src_sel_e     sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] drv_v,
  output logic [W-1:0] drv_oe
);
  function automatic logic [W-1:0] pick_inv(src_sel_e s, logic [W-1:0] l,
                                            logic [W-1:0] h);
    return ~((s == SRC_STORED) ? h : l);
  endfunction

  logic active;
  assign active = en & rst_n;

  assign drv_oe = {W{active}};
  assign drv_v  = active ? pick_inv(sel, live, held) : '0;
endmodule

// File: rtl/inv_bus_xcvr.sv
module inv_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         en_ab,
  input  logic         en_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_ext_v,
  input  logic [W-1:0] a_ext_oe,
  input  logic [W-1:0] b_ext_v,
  input  logic [W-1:0] b_ext_oe,
  output logic [W-1:0] a_drv_v,
  output logic [W-1:0] a_drv_oe,
  output logic [W-1:0] b_drv_v,
  output logic [W-1:0] b_drv_oe,
  output logic [W-1:0] a_seen,
  output logic [W-1:0] b_seen
);
  // named internal events for the checker
  logic         cap_rise_ab, cap_rise_ba;
  logic [W-1:0] stored_a, stored_b;

  xcvr_edge_cap #(.W(W)) u_cap_a (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ab), .bus(a_seen),
    .rise(cap_rise_ab), .held(stored_a)
  );

  xcvr_edge_cap #(.W(W)) u_cap_b (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ba), .bus(b_seen),
    .rise(cap_rise_ba), .held(stored_b)
  );

  xcvr_bus_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .ext_v(a_ext_v), .ext_oe(a_ext_oe),
    .own_v(a_drv_v), .own_oe(a_drv_oe), .seen(a_seen)
  );

  xcvr_bus_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .ext_v(b_ext_v), .ext_oe(b_ext_oe),
    .own_v(b_drv_v), .own_oe(b_drv_oe), .seen(b_seen)
  );

  xcvr_drive_path #(.W(W)) u_path_ab (
    .rst_n(rst_n), .en(en_ab), .sel(src_sel_e'(sel_ab)),
    .live(a_seen), .held(stored_a), .drv_v(b_drv_v), .drv_oe(b_drv_oe)
  );

  xcvr_drive_path #(.W(W)) u_path_ba (
    .rst_n(rst_n), .en(en_ba), .sel(src_sel_e'(sel_ba)),
    .live(b_seen), .held(stored_b), .drv_v(a_drv_v), .drv_oe(a_drv_oe)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_ab,
  input logic         en_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_ext_v,
  input logic [W-1:0] a_ext_oe,
  input logic [W-1:0] a_seen,
  input logic [W-1:0] b_seen,
  input logic [W-1:0] a_drv_v,
  input logic [W-1:0] a_drv_oe,
  input logic [W-1:0] b_drv_v,
  input logic [W-1:0] b_drv_oe,
  input logic         cap_rise_ab,
  input logic         cap_rise_ba,
  input logic [W-1:0] stored_a,
  input logic [W-1:0] stored_b
);
  p_capture_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise_ab |=> stored_a == $past(a_seen));

  p_capture_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise_ba |=> stored_b == $past(b_seen));

  p_no_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_rise_ab && !cap_rise_ba) |=> ($stable(stored_a) && $stable(stored_b)));

  p_live_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ab && !sel_ab) |-> b_drv_v == ~a_seen);

  p_live_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ba && !sel_ba) |-> a_drv_v == ~b_seen);

  p_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_ab && sel_ab) |-> b_drv_v == ~stored_a) and
    ((en_ba && sel_ba) |-> a_drv_v == ~stored_b));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ab |-> (b_drv_oe == '0 && b_drv_v == '0)) and
    (!en_ba |-> (a_drv_oe == '0 && a_drv_v == '0)));

  p_resolve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_seen & a_ext_oe) == (a_ext_v & a_ext_oe));

  p_reset_off_r9: assert property (@(posedge clk)
    !rst_n |-> (a_drv_oe == '0 && b_drv_oe == '0));
endmodule

bind inv_bus_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba(en_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_ext_v(a_ext_v), .a_ext_oe(a_ext_oe),
  .a_seen(a_seen), .b_seen(b_seen), .a_drv_v(a_drv_v), .a_drv_oe(a_drv_oe),
  .b_drv_v(b_drv_v), .b_drv_oe(b_drv_oe), .cap_rise_ab(cap_rise_ab),
  .cap_rise_ba(cap_rise_ba), .stored_a(stored_a), .stored_b(stored_b)
);

// File: tb/sim_inv_bus_xcvr.sv
module sim_inv_bus_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_ab = 0, cap_ba = 0, en_ab = 0, en_ba = 0, sel_ab = 0, sel_ba = 0;
  logic [7:0] a_ext_v = '0, a_ext_oe = '0, b_ext_v = '0, b_ext_oe = '0;
  logic [7:0] a_drv_v, a_drv_oe, b_drv_v, b_drv_oe, a_seen, b_seen;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  inv_bus_xcvr #(.W(8)) u0 (.*);

  typedef struct packed {
    logic       en_ab, en_ba;
    logic [7:0] a, b;
    logic [7:0] xa;  logic xaoe;
    logic [7:0] xb;  logic xboe;
  } vec_t;

  // live mode, both buses fully driven from outside
  localparam vec_t TBL [6] = '{
    '{1'b1, 1'b0, 8'h3C, 8'h00, 8'h00, 1'b0, 8'hC3, 1'b1},
    '{1'b0, 1'b1, 8'h00, 8'h5A, 8'hA5, 1'b1, 8'h00, 1'b0},
    '{1'b1, 1'b1, 8'hF0, 8'h81, 8'h7E, 1'b1, 8'h0F, 1'b1},
    '{1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b0, 8'h00, 8'h12, 8'h00, 1'b0, 8'hFF, 1'b1},
    '{1'b0, 1'b1, 8'h12, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b0}
  };

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    // R9: reset holds outputs off even with enables set
    en_ab = 1; en_ba = 1; sel_ab = 1; sel_ba = 1;
    repeat (3) at_neg();
    settle();
    check("R9 a_drv_oe in reset", a_drv_oe, 8'h00);
    check("R9 b_drv_oe in reset", b_drv_oe, 8'h00);
    at_neg(); rst_n = 1; settle();
    check("R9 cleared A register seen via stored path", b_drv_v, 8'hFF);
    check("R9 cleared B register seen via stored path", a_drv_v, 8'hFF);
    check("R9 kept A level cleared", a_seen, 8'h00);

    // table walk: R4 values, R6 drive masks
    sel_ab = 0; sel_ba = 0; a_ext_oe = 8'hFF; b_ext_oe = 8'hFF;
    for (int i = 0; i < 6; i++) begin
      at_neg();
      en_ab = TBL[i].en_ab; en_ba = TBL[i].en_ba;
      a_ext_v = TBL[i].a; b_ext_v = TBL[i].b;
      settle();
      check("R4 a_drv_v", a_drv_v, TBL[i].xa);
      check("R4 b_drv_v", b_drv_v, TBL[i].xb);
      check("R6 a_drv_oe", a_drv_oe, {8{TBL[i].xaoe}});
      check("R6 b_drv_oe", b_drv_oe, {8{TBL[i].xboe}});
    end

    // R1 and R3: capture with paths off, strobe held high while bus changes
    at_neg(); en_ab = 0; en_ba = 0; a_ext_v = 8'hA7; cap_ab = 1;
    at_neg(); a_ext_v = 8'h11;
    at_neg(); cap_ab = 0; a_ext_v = 8'h22; en_ab = 1; sel_ab = 1;
    settle();
    check("R1 R3 stored A after held strobe", b_drv_v, 8'h58);
    // R1: capture while the path is enabled in stored mode
    at_neg(); a_ext_v = 8'h0F; cap_ab = 1;
    at_neg(); cap_ab = 0; a_ext_v = 8'h00;
    settle();
    check("R1 capture with enable on", b_drv_v, 8'hF0);
    check("R5 stored A ignores live A", b_drv_v, 8'hF0);

    // R2 and R5 on the B side
    at_neg(); en_ab = 0; sel_ab = 0; b_ext_v = 8'h3E; cap_ba = 1;
    at_neg(); cap_ba = 0; b_ext_v = 8'h77; en_ba = 1; sel_ba = 1;
    settle();
    check("R2 stored B", a_drv_v, 8'hC1);
    at_neg(); b_ext_v = 8'h00; settle();
    check("R5 stored B ignores live B", a_drv_v, 8'hC1);

    // R7: partial external drive on A
    at_neg(); en_ba = 0; sel_ba = 0; a_ext_v = 8'h5C; a_ext_oe = 8'hFF;
    at_neg(); a_ext_v = 8'hA3; a_ext_oe = 8'h0F; settle();
    check("R7 mixed resolution on A", a_seen, 8'h53);

    // R8: self-holding loop
    at_neg(); en_ab = 1; en_ba = 0; sel_ab = 0; sel_ba = 0;
    a_ext_v = 8'h69; a_ext_oe = 8'hFF; b_ext_oe = 8'h00;
    at_neg(); settle();
    check("R7 B keeps own drive", b_seen, 8'h96);
    at_neg(); en_ba = 1; a_ext_oe = 8'h00;
    repeat (4) at_neg();
    settle();
    check("R8 A holds in loop", a_seen, 8'h69);
    check("R8 B holds in loop", b_seen, 8'h96);
    check("R8 A driven by loop", a_drv_v, 8'h69);
    at_neg(); en_ab = 0; en_ba = 0;
    repeat (3) at_neg();
    settle();
    check("R8 A kept after release", a_seen, 8'h69);
    check("R8 B kept after release", b_seen, 8'h96);
    check("R6 B mask off", b_drv_oe, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule